// File: doc/BRIEF.md
# Chunk Group Unpacker

This block takes fixed 64-bit fetch groups and turns each into a stream of instructions for the execution units. Every group carries five 12-bit chunks and a 4-bit control code. The code says which chunks are immediates, so instruction boundaries are known without looking inside any chunk. An instruction is either one chunk, or one instruction chunk followed by the immediate chunk that belongs to it. The block tags each instruction with its unit class and its chunk index. It then presents the instruction on the valid/ready output of the unit named by the instruction's top bits.

Instructions leave strictly in chunk order, one per cycle at most. If the unit that the next instruction needs is not ready, the whole rest of the group waits. No operand or dependency check is made. A start index supplied with the group lets a branch land part-way through it, and every chunk below that index is thrown away. An illegal control code, or an instruction naming an unassigned unit, is dropped and raises a one-cycle error pulse.

Top module: `chunk_group_unpacker`

## Requirements
- R1: While reset is held and in the first cycle after it, no issue valid is high, `grpReady` is 1 and `errFlag` is 0.
- R2: Chunk i of a group is bits [63-12i : 52-12i], and the control code is bits [3:0]. Code k (0..12) selects the k-th five-bit mask, in ascending numeric order, that has no two adjacent set bits (0,1,2,4,5,8,9,10,16,17,18,20,21). Mask bit i set means chunk i is an immediate. Every instruction chunk at or above the start index is issued exactly once, in ascending chunk order.
- R3: An instruction chunk at index i < 4 whose chunk i+1 is an immediate is issued once, with `outHasImm`=1 and `outImm` equal to chunk i+1. Otherwise `outHasImm`=0 and `outImm`=0.
- R4: The unit field is bits [11:9] of the instruction chunk (0 ALU, 1 register, 2 load/store, 3 move, 4 branch). Only `outValid[unit]` is raised for it, with `outUnit` equal to the field and `outIdx` equal to the chunk index.
- R5: A group with control code 13, 14 or 15 is accepted and issues nothing. `errFlag` is then high for exactly one cycle.
- R6: An instruction chunk whose unit field is 5, 6 or 7 is not issued. It raises `errFlag` for one cycle, and the instructions after it are still issued.
- R7: While the addressed unit's ready is low, the valid and the payload hold unchanged and later instructions wait. Readies of other units have no effect.
- R8: Chunks below `grpStart` are discarded. If the chunk at `grpStart` is an immediate, it is discarded too. A `grpStart` of 5 or more issues nothing.
- R9: `grpReady` is low from the cycle after a group is accepted until the cycle after its last instruction leaves or is dropped. For a group with nothing to issue, it is high again in the cycle right after acceptance.
- R10: At most one bit of `outValid` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| grpValid | input | 1 | Fetch group offered |
| grpData | input | 64 | Five chunks (chunk 0 at the top) and the control code in [3:0] |
| grpStart | input | 3 | First chunk index to keep |
| grpReady | output | 1 | Unpacker can take a group |
| outValid | output | 5 | Per-unit issue valid |
| outReady | input | 5 | Per-unit issue ready |
| outInstr | output | 12 | Instruction chunk |
| outImm | output | 12 | Paired immediate, zero when none |
| outHasImm | output | 1 | Immediate present |
| outIdx | output | 3 | Chunk index of the instruction |
| outUnit | output | 3 | Unit class field |
| errFlag | output | 1 | One-cycle pulse for an illegal code or an unassigned unit |

## Verification
A stalled output can coincide with other units asserting ready. The bench holds one unit's ready low for several cycles while all the others stay high, and checks that the same instruction stays presented and the group does not move on. A drop of an unassigned-unit instruction can also fall on the last chunk of a group, so the error pulse and the reopening of `grpReady` land in one cycle. A group that ends that way is sent, and the bench checks that the pulse is counted, that the earlier instructions all issued, and that the next group is accepted straight after.

// File: rtl/cgu_pkg.sv
package cgu_pkg;
  localparam int CHUNK_W    = 12;
  localparam int NUM_CHUNKS = 5;
  localparam int CTRL_W     = 4;
  localparam int UNIT_W     = 3;
  localparam int NUM_UNITS  = 5;
  localparam int GROUP_W    = NUM_CHUNKS * CHUNK_W + CTRL_W;
  localparam int BODY_W     = NUM_CHUNKS * CHUNK_W;
  localparam int IDX_W      = $clog2(NUM_CHUNKS + 1);

  typedef struct packed {
    logic load;
    logic advance;
  } strobe_t;

  typedef struct packed {
    logic              codeLegal;
    logic              loadEmpty;
    logic              unitOk;
    logic [UNIT_W-1:0] unit;
    logic              lastInstr;
  } status_t;

  typedef struct packed {
    logic                  legal;
    logic [NUM_CHUNKS-1:0] mask;
  } pattern_t;

  // Enumerate masks without neighbouring immediates in ascending order;
  // the code picks one by position in that list.
  function automatic pattern_t decodePattern(input logic [CTRL_W-1:0] code);
    pattern_t r;
    int seen;
    r = '0;
    seen = 0;
    for (int m = 0; m < (1 << NUM_CHUNKS); m++) begin
      if ((m & (m >> 1)) == 0) begin
        if (seen == int'(code) && !r.legal) begin
          r.legal = 1'b1;
          r.mask  = m[NUM_CHUNKS-1:0];
        end
        seen++;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/cgu_datapath.sv
module cgu_datapath
  import cgu_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [GROUP_W-1:0]   grpData,
  input  logic [IDX_W-1:0]     grpStart,
  output status_t              status,
  output logic [CHUNK_W-1:0]   outInstr,
  output logic [CHUNK_W-1:0]   outImm,
  output logic                 outHasImm,
  output logic [IDX_W-1:0]     outIdx,
  output logic [UNIT_W-1:0]    outUnit
);
  localparam int STEP_W = IDX_W + 1;

  logic [BODY_W-1:0]     grpReg;
  logic [NUM_CHUNKS-1:0] maskReg;
  logic [IDX_W-1:0]      pos;
  logic [CHUNK_W-1:0]    chunkArr [NUM_CHUNKS];
  logic [CHUNK_W-1:0]    curChunk;
  logic [CHUNK_W-1:0]    nxtChunk;
  logic                  hasImm;
  logic [STEP_W-1:0]     stepPos;
  logic [IDX_W-1:0]      loadPos;
  logic                  startOver;
  logic                  startIsImm;
  pattern_t              inPat;
  logic [UNIT_W-1:0]     unit;

  for (genvar i = 0; i < NUM_CHUNKS; i++) begin : g_chunk
    assign chunkArr[i] = grpReg[(NUM_CHUNKS - i) * CHUNK_W - 1 -: CHUNK_W];
  end

  assign inPat = decodePattern(grpData[CTRL_W-1:0]);

  // entry point: skip an immediate whose owner lies before the start index
  always_comb begin
    startOver  = grpStart >= IDX_W'(NUM_CHUNKS);
    startIsImm = |(inPat.mask & (NUM_CHUNKS'(1) << grpStart));
    loadPos    = startOver ? IDX_W'(NUM_CHUNKS) : grpStart + IDX_W'(startIsImm);
  end

  always_comb begin
    curChunk = '0;
    nxtChunk = '0;
    hasImm   = 1'b0;
    for (int i = 0; i < NUM_CHUNKS; i++)
      if (pos == IDX_W'(i)) curChunk = chunkArr[i];
    for (int i = 0; i < NUM_CHUNKS - 1; i++)
      if (pos == IDX_W'(i)) begin
        nxtChunk = chunkArr[i+1];
        hasImm   = maskReg[i+1];
      end
  end

  assign stepPos = {1'b0, pos} + STEP_W'(1) + STEP_W'(hasImm);
  assign unit    = curChunk[CHUNK_W-1 -: UNIT_W];

  assign status.codeLegal = inPat.legal;
  assign status.loadEmpty = loadPos >= IDX_W'(NUM_CHUNKS);
  assign status.unitOk    = unit < UNIT_W'(NUM_UNITS);
  assign status.unit      = unit;
  assign status.lastInstr = stepPos >= STEP_W'(NUM_CHUNKS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grpReg  <= '0;
      maskReg <= '0;
      pos     <= '0;
    end else if (strb.load) begin
      grpReg  <= grpData[GROUP_W-1:CTRL_W];
      maskReg <= inPat.mask;
      pos     <= loadPos;
    end else if (strb.advance) begin
      pos <= stepPos[IDX_W-1:0];
    end
  end

  assign outInstr  = curChunk;
  assign outImm    = hasImm ? nxtChunk : '0;
  assign outHasImm = hasImm;
  assign outIdx    = pos;
  assign outUnit   = unit;

  // R3
  imm_stride_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && hasImm && !status.lastInstr) |=> (pos == $past(pos) + IDX_W'(2)));

  // R8
  start_skip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && grpStart < IDX_W'(NUM_CHUNKS)) |=> (pos >= $past(grpStart)));
endmodule

// File: rtl/cgu_ctrl.sv
module cgu_ctrl
  import cgu_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 grpValid,
  output logic                 grpReady,
  input  status_t              status,
  input  logic [NUM_UNITS-1:0] outReady,
  output logic [NUM_UNITS-1:0] outValid,
  output strobe_t              strb,
  output logic                 errFlag
);
  logic busy;
  logic fire;
  logic drop;
  logic reject;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_route
    assign outValid[u] = busy && status.unitOk && (status.unit == UNIT_W'(u));
  end

  assign fire         = |(outValid & outReady);
  assign drop         = busy && !status.unitOk;
  assign grpReady     = !busy;
  assign strb.load    = grpValid && !busy && status.codeLegal;
  assign strb.advance = fire || drop;
  assign reject       = grpValid && !busy && !status.codeLegal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      errFlag <= reject || drop;
      if (strb.load)
        busy <= !status.loadEmpty;
      else if (strb.advance && status.lastInstr)
        busy <= 1'b0;
    end
  end

  // R5
  bad_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    reject |=> (errFlag && grpReady && (outValid == '0)));

  // R6
  bad_unit_chk: assert property (@(posedge clk) disable iff (!rstN)
    drop |=> errFlag);

  // R10
  one_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(outValid));
endmodule

// File: rtl/chunk_group_unpacker.sv
module chunk_group_unpacker
  import cgu_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 grpValid,
  input  logic [GROUP_W-1:0]   grpData,
  input  logic [IDX_W-1:0]     grpStart,
  output logic                 grpReady,
  output logic [NUM_UNITS-1:0] outValid,
  input  logic [NUM_UNITS-1:0] outReady,
  output logic [CHUNK_W-1:0]   outInstr,
  output logic [CHUNK_W-1:0]   outImm,
  output logic                 outHasImm,
  output logic [IDX_W-1:0]     outIdx,
  output logic [UNIT_W-1:0]    outUnit,
  output logic                 errFlag
);
  strobe_t strb;
  status_t status;

  cgu_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .grpValid (grpValid),
    .grpReady (grpReady),
    .status   (status),
    .outReady (outReady),
    .outValid (outValid),
    .strb     (strb),
    .errFlag  (errFlag)
  );

  cgu_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .grpData   (grpData),
    .grpStart  (grpStart),
    .status    (status),
    .outInstr  (outInstr),
    .outImm    (outImm),
    .outHasImm (outHasImm),
    .outIdx    (outIdx),
    .outUnit   (outUnit)
  );

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(outValid & ~outReady)) |=> ((outValid == $past(outValid)) && $stable(outInstr)
                                   && $stable(outIdx) && $stable(outImm)));

  // R9
  busy_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|outValid) |-> !grpReady);
endmodule

// File: tb/chunk_group_unpacker_test.sv
module chunk_group_unpacker_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic        grpValid;
  logic [63:0] grpData;
  logic [2:0]  grpStart;
  logic        grpReady;
  logic [4:0]  outValid;
  logic [4:0]  outReady;
  logic [11:0] outInstr;
  logic [11:0] outImm;
  logic        outHasImm;
  logic [2:0]  outIdx;
  logic [2:0]  outUnit;
  logic        errFlag;

  always #10 clk = ~clk;

  chunk_group_unpacker uut (
    .clk(clk), .rstN(rstN), .grpValid(grpValid), .grpData(grpData),
    .grpStart(grpStart), .grpReady(grpReady), .outValid(outValid),
    .outReady(outReady), .outInstr(outInstr), .outImm(outImm),
    .outHasImm(outHasImm), .outIdx(outIdx), .outUnit(outUnit), .errFlag(errFlag)
  );

  int total = 0;
  int bad = 0;
  int maskTab [13] = '{0, 1, 2, 4, 5, 8, 9, 10, 16, 17, 18, 20, 21};
  int expN;
  int expErr;
  int expIdx   [8];
  int expInstr [8];
  int expImm   [8];
  int expHas   [8];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] chunkOf(input logic [63:0] d, input int i);
    return d[63 - 12*i -: 12];
  endfunction

  // expected issue list from the requirements
  task automatic buildExpect(input logic [63:0] d, input int start);
    int code, mask, p, has;
    logic [11:0] c;
    code = int'(d[3:0]);
    expN = 0;
    expErr = 0;
    if (code > 12) begin
      expErr = 1;
      return;
    end
    mask = maskTab[code];
    p = start;
    if (p < 5 && ((mask >> p) & 1) == 1) p++;
    while (p < 5) begin
      has = (p < 4) ? ((mask >> (p + 1)) & 1) : 0;
      c = chunkOf(d, p);
      if (c[11:9] < 3'd5) begin
        expIdx[expN]   = p;
        expInstr[expN] = int'(c);
        expHas[expN]   = has;
        expImm[expN]   = has != 0 ? int'(chunkOf(d, p + 1)) : 0;
        expN++;
      end else begin
        expErr++;
      end
      p += 1 + has;
    end
  endtask

  function automatic logic [63:0] makeGroup(input int code, input int seed);
    logic [63:0] d;
    int mask;
    mask = maskTab[code % 13];
    d = '0;
    for (int i = 0; i < 5; i++) begin
      if (((mask >> i) & 1) == 1)
        d[63 - 12*i -: 12] = {3'b111, 9'(seed * 8 + i + 1)};
      else
        d[63 - 12*i -: 12] = {3'((i + seed) % 5), 9'(seed * 16 + i)};
    end
    d[3:0] = 4'(code);
    return d;
  endfunction

  task automatic sendGroup(input logic [63:0] d, input logic [2:0] start, input string req);
    check(grpReady == 1'b1, req, "grpReady before send", grpReady, 1);
    buildExpect(d, int'(start));
    grpValid = 1'b1;
    grpData  = d;
    grpStart = start;
    @(negedge clk);
    grpValid = 1'b0;
  endtask

  task automatic collect(input string req);
    int k, errSeen, cyc;
    k = 0; errSeen = 0; cyc = 0;
    forever begin
      if (errFlag) errSeen++;
      if (|outValid) begin
        if (k < expN) begin
          check(outValid == (5'd1 << expInstr[k][11:9]), req, "R4/R10 valid vector",
                outValid, 5'd1 << expInstr[k][11:9]);
          check(int'(outIdx) == expIdx[k], req, "R4 index", outIdx, expIdx[k]);
          check(int'(outInstr) == expInstr[k], req, "R2 instr", outInstr, expInstr[k]);
          check(int'(outUnit) == (expInstr[k] >> 9), req, "R4 unit", outUnit, expInstr[k] >> 9);
          check(int'(outHasImm) == expHas[k], req, "R3 hasImm", outHasImm, expHas[k]);
          check(int'(outImm) == expImm[k], req, "R3 imm", outImm, expImm[k]);
          check(grpReady == 1'b0, req, "R9 ready while busy", grpReady, 0);
        end else begin
          check(1'b0, req, "R2 extra instruction idx", outIdx, 0);
        end
        k++;
      end
      if (grpReady) break;
      cyc++;
      if (cyc > 50) begin
        check(1'b0, req, "R9 group never finished", cyc, 50);
        break;
      end
      @(negedge clk);
    end
    check(k == expN, req, "R2 issued count", k, expN);
    check(errSeen == expErr, req, "R5/R6 error pulses", errSeen, expErr);
  endtask

  task automatic testReset();
    check(outValid == 5'd0 && grpReady && !errFlag, "R1", "reset outputs",
          {outValid, grpReady, errFlag}, 7'b0000010);
  endtask

  task automatic testAllCodes();
    for (int code = 0; code < 13; code++) begin
      sendGroup(makeGroup(code, code + 1), 3'd0, "R2");
      collect("R2");
    end
  endtask

  task automatic testPairing();
    // code 12: chunks 0,2,4 immediates -> chunk0 orphan, 1+2, 3+4
    sendGroup(makeGroup(12, 7), 3'd0, "R3");
    collect("R3");
    check(expN == 2 && expHas[1] == 1 && expIdx[1] == 3, "R3", "model pairing", expN, 2);
  endtask

  task automatic testIllegal();
    for (int code = 13; code < 16; code++) begin
      logic [63:0] d;
      d = makeGroup(0, code);
      d[3:0] = 4'(code);
      sendGroup(d, 3'd0, "R5");
      collect("R5");
      check(errFlag == 1'b1, "R5", "error pulse present", errFlag, 1);
      @(negedge clk);
      check(errFlag == 1'b0, "R5", "error pulse one cycle", errFlag, 0);
    end
  endtask

  task automatic testBadUnit();
    logic [63:0] d;
    d = makeGroup(0, 2);
    d[63 - 24 -: 12] = {3'd6, 9'h055};
    d[63 - 48 -: 12] = {3'd7, 9'h0AA};
    sendGroup(d, 3'd0, "R6");
    collect("R6");
    @(negedge clk);
    check(errFlag == 1'b0, "R6", "pulse ends", errFlag, 0);
  endtask

  task automatic testStart();
    sendGroup(makeGroup(0, 3), 3'd2, "R8");
    collect("R8");
    sendGroup(makeGroup(6, 4), 3'd3, "R8");
    collect("R8");
    check(expN == 1, "R8", "model start-on-immediate", expN, 1);
    sendGroup(makeGroup(0, 5), 3'd6, "R8");
    check(grpReady == 1'b1 && outValid == 5'd0, "R8", "start beyond group",
          {grpReady, outValid}, 6'b100000);
    collect("R8");
  endtask

  task automatic testStall();
    logic [63:0] d;
    d = makeGroup(0, 1);
    outReady = 5'b11101;
    sendGroup(d, 3'd0, "R7");
    for (int i = 0; i < 4; i++) begin
      check(outValid == 5'b00010, "R7", "held valid", outValid, 5'b00010);
      check(outIdx == 3'd0 && outInstr == chunkOf(d, 0), "R7", "held payload",
            outInstr, chunkOf(d, 0));
      check(grpReady == 1'b0, "R9", "blocked during stall", grpReady, 0);
      @(negedge clk);
    end
    outReady = 5'b11111;
    collect("R7");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    grpValid = 1'b0;
    grpData = '0;
    grpStart = '0;
    outReady = 5'b11111;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testAllCodes();
    testPairing();
    testIllegal();
    testBadUnit();
    testStart();
    testStall();
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule